// File: doc/BRIEF.md
# Pipelined Burst SRAM with Double-Cycle Deselect

This block is a synthesizable behavioural model of a synchronous burst static RAM. Words are split into byte lanes (four lanes of nine bits by default), and the depth is a parameter. Every control input is sampled on the rising clock edge. An access is opened by one of two address strobes: a processor strobe, which always starts with a read, or a controller strobe, which can write in its own cycle. Later cycles with both strobes inactive continue the open access. They either step a two-bit wrap-around burst counter or hold the current word. The burst order is interleaved or linear, picked by a parameter.

Read data leaves through an output register one edge after the access is sampled. The data bus is modelled as separate write and read ports. A drive indication shows when the real part would drive its pins. It combines a pipelined enable register with the asynchronous output-enable input. A deselect turns the drive off only one edge after it is registered, so banks can be placed side by side without a wait state. Writes force the drive off, and it stays off until a strobe starts a new read.

Top module: `sbs_sram`

## Requirements
- R1: The part is selected only when, at an edge where an address is loaded, sel_a_n_i is 0, sel_b_i is 1 and sel_c_n_i is 0. Otherwise the cycle is a deselect that writes nothing, and the continuation cycles that follow do nothing until a selecting load occurs.
- R2: If both strobes are low while sel_a_n_i is 0, only the processor strobe counts. While sel_a_n_i is 1 the processor strobe is ignored: the controller strobe decides alone, or with both strobes seen as inactive the cycle continues the open burst.
- R3: An access opened by the processor strobe is a read, whatever the write controls say. A write given on the next cycle, with no strobe, stores to that same address, so this write takes two cycles.
- R4: An access opened by the controller strobe, with the processor strobe not recognised and the write controls active, writes its data in that single cycle.
- R5: wr_all_n_i = 0 writes every lane. Otherwise, with wr_byte_n_i = 0, lane i (bits 9i+8 down to 9i) is written when lane_n_i[i] = 0. Unwritten lanes keep their contents. wr_byte_n_i = 0 with every lane_n_i bit at 1 is a read.
- R6: The data of a read sampled at one edge appears on rdata_o after the following edge.
- R7: In a continuation cycle, adv_n_i = 0 steps a two-bit counter that is cleared at each load; adv_n_i = 1 holds it. The low two address bits are start XOR step (interleaved, LINEAR_BURST = 0) or start + step modulo 4 (LINEAR_BURST = 1). The upper bits stay at the loaded address. The step wraps from 3 to 0.
- R8: After reset drive_o is 0. A deselect registered at edge k leaves the drive as it was until edge k+1, and the drive is off after edge k+1.
- R9: For a read that leaves a deselected state, drive_o stays 0 in the cycle after the strobe edge, whatever oe_n_i is. It turns on with the data one edge later.
- R10: After an edge that performs a write, drive_o is 0. Later reads by continuation keep it 0 until a strobe starts a read.
- R11: drive_o is the internal enable gated by oe_n_i without a clock: oe_n_i = 1 turns it off at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | $clog2(DEPTH) | Word address, taken when a strobe is recognised |
| sel_a_n_i | input | 1 | Select, active low; also gates the processor strobe |
| sel_b_i | input | 1 | Select, active high |
| sel_c_n_i | input | 1 | Select, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Write every lane, active low |
| wr_byte_n_i | input | 1 | Enable per-lane writes, active low |
| lane_n_i | input | LANES | Per-lane write selects, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | High when the data pins would be driven |

## Verification
The point where two functions meet in one cycle is a deselect followed directly by a processor-strobe read. At the edge after the deselect, the double-cycle turn-off and the masking of the first read cycle both act on the same enable register. The bench deselects with the controller strobe while the first select is high, opens a read on the very next edge, and expects the drive on, then off, then on with the new data across three edges. A second case puts both strobes low together with an active global write. It is judged by reading back unchanged data with the drive on.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   // Kind of access decided at a clock edge
   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,   // nothing open, nothing done
      OP_RD    = 2'd1,   // read of the current word
      OP_WR    = 2'd2,   // write of the current word
      OP_DESEL = 2'd3    // strobe with the part not selected
   } sbs_op_e;

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
   import sbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             pstb_n,
   input  logic             cstb_n,
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             active_q,
   output sbs_op_e          op,
   output logic             load,
   output logic             strobe_rd,
   output logic             advance,
   output logic [LANES-1:0] wmask
);

   logic p_seen;
   logic c_seen;
   logic chosen;
   logic any_wr;

   always_comb begin
      // processor strobe counts only with the first select low
      p_seen = !pstb_n && !sel_a_n;
      c_seen = !p_seen && !cstb_n;
      load   = p_seen || c_seen;
      chosen = !sel_a_n && sel_b && !sel_c_n;

      if (!wr_all_n)       wmask = '1;
      else if (!wr_byte_n) wmask = ~lane_n;
      else                 wmask = '0;
      any_wr = |wmask;

      op = OP_NOP;
      if (load) begin
         if (!chosen)               op = OP_DESEL;
         else if (p_seen || !any_wr) op = OP_RD;
         else                        op = OP_WR;
      end else if (active_q) begin
         op = any_wr ? OP_WR : OP_RD;
      end

      strobe_rd = load && (op == OP_RD);
      advance   = !load && active_q && !adv_n;
   end

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
   parameter int LINEAR_BURST = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       advance,
   input  logic [1:0] start_i,
   output logic [1:0] lo_o
);

   logic [1:0] base_q;
   logic [1:0] step_q;
   logic [1:0] step_eff;
   logic [1:0] walk;

   assign step_eff = advance ? step_q + 2'd1 : step_q;

   generate
      if (LINEAR_BURST != 0) begin : g_linear
         assign walk = base_q + step_eff;
      end else begin : g_interleave
         assign walk = base_q ^ step_eff;
      end
   endgenerate

   assign lo_o = load ? start_i : walk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= 2'd0;
         step_q <= 2'd0;
      end else if (load) begin
         base_q <= start_i;
         step_q <= 2'd0;
      end else begin
         step_q <= step_eff;
      end
   end

   // a cycle with neither load nor advance addresses the same low bits as the last
   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !load && !advance) |-> (lo_o == $past(lo_o))); // R7

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] wmask,
   input  logic [AW-1:0]    waddr,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rdata
);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_W-1:0] cells [DEPTH];

         always_ff @(posedge clk) begin
            if (we && wmask[l])
               cells[waddr] <= wdata[l*LANE_W +: LANE_W];
         end

         assign rdata[l*LANE_W +: LANE_W] = cells[raddr];
      end
   endgenerate

endmodule

// File: rtl/sbs_outpipe.sv
module sbs_outpipe
   import sbs_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sbs_op_e       op,
   input  logic          drv_rd_i,
   input  logic [AW-1:0] maddr_i,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          oe_n_i,
   output logic [AW-1:0] raddr_o,
   output logic [DW-1:0] rdata_o,
   output logic          drive_o
);

   logic          rd_v_q;
   logic          drv_rd_q;
   logic [AW-1:0] raddr_q;
   logic [DW-1:0] rdata_q;
   logic          drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v_q   <= 1'b0;
         drv_rd_q <= 1'b0;
         raddr_q  <= '0;
         rdata_q  <= '0;
         drive_q  <= 1'b0;
      end else begin
         rd_v_q   <= (op == OP_RD);
         drv_rd_q <= drv_rd_i;
         raddr_q  <= maddr_i;
         if (rd_v_q) rdata_q <= mem_rdata_i;
         // a write switches the drive off at once; otherwise it follows the previous access
         drive_q  <= (op == OP_WR) ? 1'b0 : drv_rd_q;
      end
   end

   assign raddr_o = raddr_q;
   assign rdata_o = rdata_q;
   assign drive_o = drive_q & ~oe_n_i;

   AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR) |=> !drive_q); // R10

   AST_DCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DESEL) |=> ##1 !drive_q); // R8

   AST_DRV_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_q) |-> ($past(op, 2) == OP_RD)); // R9

endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
   import sbs_pkg::*;
#(
   parameter int DEPTH        = 256,
   parameter int LANES        = 4,
   parameter int LANE_W       = 9,
   parameter int LINEAR_BURST = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(DEPTH)-1:0]   addr_i,
   input  logic                       sel_a_n_i,
   input  logic                       sel_b_i,
   input  logic                       sel_c_n_i,
   input  logic                       pstb_n_i,
   input  logic                       cstb_n_i,
   input  logic                       adv_n_i,
   input  logic                       wr_all_n_i,
   input  logic                       wr_byte_n_i,
   input  logic [LANES-1:0]           lane_n_i,
   input  logic [LANES*LANE_W-1:0]    wdata_i,
   input  logic                       oe_n_i,
   output logic [LANES*LANE_W-1:0]    rdata_o,
   output logic                       drive_o
);

   localparam int AW = $clog2(DEPTH);
   localparam int DW = LANES * LANE_W;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("LANES and LANE_W must be positive");
      end
   endgenerate

   sbs_op_e          op;
   logic             load;
   logic             strobe_rd;
   logic             advance;
   logic [LANES-1:0] wmask;
   logic             active_q;
   logic             rd_ok_q;
   logic [AW-3:0]    hi_q;
   logic [1:0]       lo;
   logic [AW-1:0]    maddr;
   logic [AW-1:0]    raddr;
   logic [DW-1:0]    mem_rdata;
   logic             drv_rd;

   sbs_decode #(.LANES(LANES)) i_decode (
      .pstb_n   (pstb_n_i),
      .cstb_n   (cstb_n_i),
      .sel_a_n  (sel_a_n_i),
      .sel_b    (sel_b_i),
      .sel_c_n  (sel_c_n_i),
      .adv_n    (adv_n_i),
      .wr_all_n (wr_all_n_i),
      .wr_byte_n(wr_byte_n_i),
      .lane_n   (lane_n_i),
      .active_q (active_q),
      .op       (op),
      .load     (load),
      .strobe_rd(strobe_rd),
      .advance  (advance),
      .wmask    (wmask)
   );

   sbs_burst_ctr #(.LINEAR_BURST(LINEAR_BURST)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (advance),
      .start_i (addr_i[1:0]),
      .lo_o    (lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_ok_q  <= 1'b0;
         hi_q     <= '0;
      end else begin
         if (load) begin
            active_q <= (op != OP_DESEL);
            hi_q     <= addr_i[AW-1:2];
         end
         if (op == OP_DESEL || op == OP_WR) rd_ok_q <= 1'b0;
         else if (strobe_rd)                rd_ok_q <= 1'b1;
      end
   end

   assign maddr  = {(load ? addr_i[AW-1:2] : hi_q), lo};
   assign drv_rd = (op == OP_RD) && (strobe_rd || rd_ok_q);

   sbs_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk   (clk),
      .we    (op == OP_WR),
      .wmask (wmask),
      .waddr (maddr),
      .wdata (wdata_i),
      .raddr (raddr),
      .rdata (mem_rdata)
   );

   sbs_outpipe #(.AW(AW), .DW(DW)) i_outpipe (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .drv_rd_i    (drv_rd),
      .maddr_i     (maddr),
      .mem_rdata_i (mem_rdata),
      .oe_n_i      (oe_n_i),
      .raddr_o     (raddr),
      .rdata_o     (rdata_o),
      .drive_o     (drive_o)
   );

   AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !load) |-> (op != OP_WR)); // R1

   AST_WR_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_WR) |-> (wmask != '0)); // R5

endmodule

// File: tb/test_sbs_sram.sv
module test_sbs_sram;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr;
   logic        sel_a_n, sel_b, sel_c_n;
   logic        pstb_n, cstb_n, adv_n;
   logic        wr_all_n, wr_byte_n;
   logic [3:0]  lane_n;
   logic [35:0] wdata;
   logic        oe_n;
   logic [35:0] rd_i, rd_l;
   logic        drv_i, drv_l;

   int n_run  = 0;
   int n_fail = 0;
   logic [35:0] sh [256];

   localparam logic [35:0] JUNK = 36'hF_FFFF_FFFF;

   always #10 clk = ~clk;

   sbs_sram #(.LINEAR_BURST(0)) i_sbs_sram (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_a_n_i(sel_a_n), .sel_b_i(sel_b),
      .sel_c_n_i(sel_c_n), .pstb_n_i(pstb_n), .cstb_n_i(cstb_n), .adv_n_i(adv_n),
      .wr_all_n_i(wr_all_n), .wr_byte_n_i(wr_byte_n), .lane_n_i(lane_n),
      .wdata_i(wdata), .oe_n_i(oe_n), .rdata_o(rd_i), .drive_o(drv_i));

   sbs_sram #(.LINEAR_BURST(1)) i_sbs_sram_lin (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_a_n_i(sel_a_n), .sel_b_i(sel_b),
      .sel_c_n_i(sel_c_n), .pstb_n_i(pstb_n), .cstb_n_i(cstb_n), .adv_n_i(adv_n),
      .wr_all_n_i(wr_all_n), .wr_byte_n_i(wr_byte_n), .lane_n_i(lane_n),
      .wdata_i(wdata), .oe_n_i(oe_n), .rdata_o(rd_l), .drive_o(drv_l));

   function automatic logic [35:0] wd(input int a);
      return {4'hC, 8'(a), 8'(a + 1), 8'(a + 2), 8'(a + 3)};
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic idle();
      addr = 8'h00; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
      wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_n = 4'hF; wdata = '0; oe_n = 1'b0;
   endtask

   task automatic ctrl_write(input logic [7:0] a, input logic [35:0] d);
      cstb_n = 1'b0; wr_all_n = 1'b0; addr = a; wdata = d;
      tick();
      idle();
      sh[a] = d;
   endtask

   task automatic t_reset();
      idle();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      chk("R8 reset drive off", {35'd0, drv_i}, 36'd0);
      chk("R6 reset read data", rd_i, 36'd0);
   endtask

   task automatic t_ctrl_writes();
      for (int a = 16; a < 20; a++) ctrl_write(8'(a), wd(a));
      ctrl_write(8'h20, wd(32));
      ctrl_write(8'h21, wd(33));
      chk("R10 drive off after write", {35'd0, drv_i}, 36'd0);
   endtask

   task automatic t_proc_read();
      pstb_n = 1'b0; wr_all_n = 1'b0; wdata = JUNK; addr = 8'h10;
      tick();
      idle();
      chk("R10 still off on strobe edge after writes", {35'd0, drv_i}, 36'd0);
      tick();
      chk("R3 processor strobe reads despite write", rd_i, sh[8'h10]);
      chk("R4 controller write stored", rd_i, wd(16));
      chk("R6 drive on with data", {35'd0, drv_i}, 36'd1);
      oe_n = 1'b1; #1;
      chk("R11 oe high gates drive", {35'd0, drv_i}, 36'd0);
      oe_n = 1'b0; #1;
      chk("R11 oe low restores drive", {35'd0, drv_i}, 36'd1);
   endtask

   task automatic t_burst();
      cstb_n = 1'b0; addr = 8'h11; adv_n = 1'b0;
      tick();
      cstb_n = 1'b1;
      tick();
      chk("R7 burst first interleaved", rd_i, sh[8'h11]);
      chk("R7 burst first linear", rd_l, sh[8'h11]);
      tick();
      chk("R7 burst second interleaved", rd_i, sh[8'h10]);
      chk("R7 burst second linear", rd_l, sh[8'h12]);
      tick();
      chk("R7 burst third interleaved", rd_i, sh[8'h13]);
      chk("R7 burst third linear", rd_l, sh[8'h13]);
      adv_n = 1'b1;
      tick();
      chk("R7 burst fourth interleaved", rd_i, sh[8'h12]);
      chk("R7 burst fourth linear", rd_l, sh[8'h10]);
      adv_n = 1'b0;
      tick();
      chk("R7 hold repeats interleaved", rd_i, sh[8'h12]);
      chk("R7 hold repeats linear", rd_l, sh[8'h10]);
      adv_n = 1'b1;
      tick();
      chk("R7 wrap interleaved", rd_i, sh[8'h11]);
      chk("R7 wrap linear", rd_l, sh[8'h11]);
      idle();
   endtask

   task automatic t_ce1_and_deselect();
      cstb_n = 1'b0; addr = 8'h10;
      tick();
      idle();
      pstb_n = 1'b0; sel_a_n = 1'b1; adv_n = 1'b0;
      tick();
      idle();
      chk("R6 read of loaded word", rd_i, sh[8'h10]);
      chk("R2 drive on before ignored strobe", {35'd0, drv_i}, 36'd1);
      // controller strobe with first select high: deselect, processor strobe ignored
      cstb_n = 1'b0; pstb_n = 1'b0; sel_a_n = 1'b1;
      tick();
      idle();
      chk("R2 ignored processor strobe continued burst", rd_i, sh[8'h11]);
      chk("R8 drive held one cycle after deselect", {35'd0, drv_i}, 36'd1);
      pstb_n = 1'b0; addr = 8'h13;
      tick();
      idle();
      chk("R8 drive off after second edge", {35'd0, drv_i}, 36'd0);
      chk("R9 linear copy also off", {35'd0, drv_l}, 36'd0);
      tick();
      chk("R9 drive on with read data", {35'd0, drv_i}, 36'd1);
      chk("R9 read data after deselect", rd_i, sh[8'h13]);
   endtask

   task automatic t_priority();
      pstb_n = 1'b0; cstb_n = 1'b0; wr_all_n = 1'b0; wdata = JUNK; addr = 8'h12;
      tick();
      idle();
      tick();
      chk("R2 both strobes read not write", rd_i, sh[8'h12]);
      chk("R2 both strobes drive on", {35'd0, drv_i}, 36'd1);
      tick();
      chk("R2 word kept after both strobes", rd_i, sh[8'h12]);
   endtask

   task automatic t_byte_write();
      logic [35:0] nv;
      nv = 36'h1_2345_6789;
      pstb_n = 1'b0; addr = 8'h20;
      tick();
      idle();
      wr_byte_n = 1'b0; lane_n = 4'b1010; wdata = nv;
      tick();
      idle();
      chk("R10 drive off after second-cycle write", {35'd0, drv_i}, 36'd0);
      for (int l = 0; l < 4; l++)
         if (l == 0 || l == 2) sh[8'h20][l*9 +: 9] = nv[l*9 +: 9];
      pstb_n = 1'b0; addr = 8'h20;
      tick();
      idle();
      tick();
      chk("R3 two-cycle write with R5 lane mask", rd_i, sh[8'h20]);
      cstb_n = 1'b0; addr = 8'h21; wr_byte_n = 1'b0; lane_n = 4'hF; wdata = JUNK;
      tick();
      idle();
      tick();
      chk("R5 no lane selected reads", rd_i, sh[8'h21]);
      chk("R5 no lane selected drives", {35'd0, drv_i}, 36'd1);
   endtask

   task automatic t_write_quiet();
      logic [35:0] v;
      v = 36'h0_ABCD_EF01;
      ctrl_write(8'h30, v);
      chk("R10 drive off after controller write", {35'd0, drv_i}, 36'd0);
      tick();
      tick();
      chk("R10 continued read stays off", {35'd0, drv_i}, 36'd0);
      chk("R10 continued read data", rd_i, v);
   endtask

   task automatic t_deselect_nowrite();
      cstb_n = 1'b0; sel_b = 1'b0; wr_all_n = 1'b0; wdata = JUNK; addr = 8'h11;
      tick();
      idle();
      wr_all_n = 1'b0; wdata = JUNK;
      tick();
      idle();
      cstb_n = 1'b0; sel_c_n = 1'b1; wr_all_n = 1'b0; wdata = JUNK; addr = 8'h11;
      tick();
      idle();
      pstb_n = 1'b0; addr = 8'h11;
      tick();
      idle();
      chk("R9 first read cycle masked", {35'd0, drv_i}, 36'd0);
      tick();
      chk("R1 deselected cycles wrote nothing", rd_i, sh[8'h11]);
      chk("R1 read after deselect drives", {35'd0, drv_i}, 36'd1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) sh[i] = '0;
      t_reset();
      t_ctrl_writes();
      t_proc_read();
      t_burst();
      t_ce1_and_deselect();
      t_priority();
      t_byte_write();
      t_write_quiet();
      t_deselect_nowrite();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule